// File: doc/BRIEF.md
# NRZI Transmit Bit Serializer

This block turns a stream of 16-bit words from an upstream framer into a single NRZI-coded line. It emits one channel bit per symbol tick. A parameterized clock-enable divider produces the ticks. With the default divide ratio and a 125 MHz clock, the rate is close to 1200 symbols per second. Each word is accepted through a valid/ready handshake and is sent least significant bit first. A data 0 flips the line level and a data 1 keeps it.

Internally a 17-bit shift register holds the word under a marker bit. When everything above bit 0 has drained to zero, the register is exhausted and the next tick fetches a fresh word. The line is driven one symbol behind the level computation. On each tick the output takes the level computed on the tick before, and then the next level is computed from the current data bit. If no word is offered at a refill tick, sixteen ones are sent instead, which hold the line, and an underrun pulse is raised. While transmission is disabled, the line rests at a parameter-chosen idle level.

Top module: `nrzi_tx_serializer`

## Requirements
- R1: While reset is held and in the first cycle after it, `line_out` equals IDLE_LEVEL, and `word_ready`, `underrun` and `tx_active` are 0.
- R2: With `tx_en` high, a symbol tick occurs once every TICK_DIV clock cycles. The first tick comes TICK_DIV cycles after `tx_en` rises. `line_out` changes only on the clock edge that ends a tick cycle, or when transmission is disabled.
- R3: At each tick, `line_out` takes the level that was computed at the previous tick. At the first tick after enabling, it takes IDLE_LEVEL.
- R4: The next level is NOT(current computed level XOR data bit). A data 0 toggles the level and a data 1 holds it.
- R5: Each accepted 16-bit word is sent in exactly 16 consecutive ticks, with bit 0 first and bit 15 last.
- R6: `word_ready` is 1 only during a tick cycle in which the shift register is exhausted. This happens at the first tick after enabling and at every 16th tick after a refill. A word offered with `word_valid` in that cycle is taken, and its bit 0 is encoded in the same tick.
- R7: If `word_valid` is 0 at a refill tick, the word 0xFFFF is sent instead. `underrun` is then 1 for exactly the one cycle after that tick.
- R8: When `tx_en` is low, `line_out` is IDLE_LEVEL from the next clock edge onward and the shift register is cleared. Any unsent bits are dropped, and after re-enabling, the first tick fetches a new word.
- R9: `tx_active` follows `tx_en` with a delay of one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low forces the idle level |
| word_data | input | 16 | Word from the framer, bit 0 sent first |
| word_valid | input | 1 | `word_data` is offered |
| word_ready | output | 1 | Word is taken in this cycle (refill tick) |
| line_out | output | 1 | NRZI line level |
| tx_active | output | 1 | Registered copy of `tx_en` |
| underrun | output | 1 | One-cycle pulse after a refill tick with no word offered |

## Verification
The refill and the emission of a symbol share one tick. In that cycle the register is reloaded, bit 0 of the new word is encoded, and the line takes the level left by the previous word's last bit. At the 16th-to-17th bit boundary, the bench checks `word_ready` inside the tick cycle and `line_out` just after it. The expected levels come from a bit-index model of its own. The same boundary is provoked with `word_valid` low to make the underrun fill coincide with the refill. It is also provoked right after re-enabling from a mid-word disable, where the refill coincides with the idle-level restart.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  // NRZI rule: a 0 flips the level, a 1 keeps it
  function automatic logic nrzi_next_level(input logic cur_level, input logic data_bit);
    return ~(cur_level ^ data_bit);
  endfunction

  // divider counter width for a given ratio
  function automatic int div_cnt_width(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/nrzi_tick_div.sv
module nrzi_tick_div #(
  parameter int TICK_DIV = 104167
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  import nrzi_tx_pkg::*;

  localparam int CW = div_cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2

endmodule

// File: rtl/nrzi_word_shifter.sv
module nrzi_word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              data_bit,
  output logic              underrun
);
  localparam int SR_W = WORD_W + 1;

  logic [SR_W-1:0] sreg;
  logic [SR_W-1:0] src;
  logic            exhausted;
  logic            refill;
  logic [WORD_W-1:0] fill_word;

  assign exhausted  = ~|sreg[SR_W-1:1];
  assign refill     = tick && en && exhausted;
  assign word_ready = refill;
  assign fill_word  = word_valid ? word_data : {WORD_W{1'b1}};
  assign src        = refill ? {1'b1, fill_word} : sreg;
  assign data_bit   = src[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= refill && !word_valid;
      if (!en)       sreg <= '0;
      else if (tick) sreg <= src >> 1;
    end
  end

  AST_SENTINEL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    refill |=> sreg[SR_W-2]); // R5
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R7
  AST_CLEARED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sreg == '0)); // R8

endmodule

// File: rtl/nrzi_level_enc.sv
module nrzi_level_enc #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic data_bit,
  output logic line_out
);
  import nrzi_tx_pkg::*;

  logic next_level;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      next_level <= IDLE_LEVEL;
      line_out   <= IDLE_LEVEL;
    end else if (tick) begin
      line_out   <= next_level;
      next_level <= nrzi_next_level(next_level, data_bit);
    end
  end

  AST_HOLD_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && data_bit) |=> (next_level == $past(next_level))); // R4
  AST_TOGGLE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !data_bit) |=> (next_level != $past(next_level))); // R4
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (line_out == IDLE_LEVEL)); // R8

endmodule

// File: rtl/nrzi_tx_serializer.sv
module nrzi_tx_serializer #(
  parameter int   WORD_W     = 16,
  parameter int   TICK_DIV   = 104167,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              line_out,
  output logic              tx_active,
  output logic              underrun
);

  logic sym_tick;
  logic cur_bit;

  nrzi_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tx_en),
    .tick (sym_tick)
  );

  nrzi_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .tick      (sym_tick),
    .word_data (word_data),
    .word_valid(word_valid),
    .word_ready(word_ready),
    .data_bit  (cur_bit),
    .underrun  (underrun)
  );

  nrzi_level_enc #(.IDLE_LEVEL(IDLE_LEVEL)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .tick    (sym_tick),
    .data_bit(cur_bit),
    .line_out(line_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_active <= 1'b0;
    else        tx_active <= tx_en;
  end

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !sym_tick) |=> $stable(line_out)); // R2
  AST_READY_IN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> !word_ready); // R6
  AST_ACTIVE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> tx_active); // R9

endmodule

// File: tb/tb_nrzi_tx_serializer.sv
`timescale 1ns/1ps
module tb_nrzi_tx_serializer;
  localparam int   DIV  = 3;
  localparam logic IDLE = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [15:0] word_data = 16'h0;
  logic        word_valid = 1'b0;
  logic        word_ready, line_out, tx_active, underrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int          bidx;
  logic [15:0] cur_word;
  logic        lvl_next;
  int          wp = 0;
  logic [15:0] words [8];

  always #4 clk = ~clk;

  nrzi_tx_serializer #(.WORD_W(16), .TICK_DIV(DIV), .IDLE_LEVEL(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .line_out(line_out),
    .tx_active(tx_active), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_restart();
    bidx = 16;
    lvl_next = IDLE;
  endtask

  // one symbol: checks R2, R3, R4, R5, R6, R7, R9
  task automatic sym();
    logic refill, exp_line, exp_und, b;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    refill = (bidx == 16);
    chk("R6 ready in tick", word_ready, refill);
    exp_und = 1'b0;
    if (refill) begin
      cur_word = word_valid ? word_data : 16'hFFFF;
      exp_und = !word_valid;
      bidx = 0;
    end
    b = cur_word[bidx];
    bidx++;
    exp_line = lvl_next;
    lvl_next = (b == 1'b1) ? lvl_next : ~lvl_next;
    @(posedge clk);
    @(negedge clk);
    chk("R3/R4/R5 line level", line_out, exp_line);
    chk("R7 underrun pulse", underrun, exp_und);
    chk("R2 ready off between ticks", word_ready, 1'b0);
    chk("R9 tx_active", tx_active, 1'b1);
    if (refill && word_valid) begin
      wp = (wp + 1) % 8;
      word_data = words[wp];
    end
  endtask

  initial begin
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hA5C3;
    words[3] = 16'h1234; words[4] = 16'h8001; words[5] = 16'h00FF;
    words[6] = 16'h5A5A; words[7] = 16'hC00C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 line idle in reset", line_out, IDLE);
    chk("R1 ready low", word_ready, 1'b0);
    chk("R1 underrun low", underrun, 1'b0);
    chk("R1 tx_active low", tx_active, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 line idle after reset", line_out, IDLE);
    chk("R1 tx_active low after reset", tx_active, 1'b0);

    // back-to-back words
    word_data = words[0];
    word_valid = 1'b1;
    tx_en = 1'b1;
    model_restart();
    @(posedge clk); @(negedge clk);
    chk("R9 tx_active rises", tx_active, 1'b1);
    chk("R2 line quiet before first tick", line_out, IDLE);
    // one cycle already used: DIV cycles after enable the first tick ends
    repeat (DIV - 2) @(posedge clk);
    @(negedge clk);
    chk("R6 first tick ready", word_ready, 1'b1);
    cur_word = word_data; bidx = 1;
    @(posedge clk); @(negedge clk);
    chk("R3 first tick drives idle", line_out, IDLE);
    lvl_next = cur_word[0] ? IDLE : ~IDLE;
    wp = 1; word_data = words[1];
    for (int i = 0; i < 79; i++) sym();

    // underrun: no word at the refill tick
    word_valid = 1'b0;
    for (int i = 0; i < 17; i++) sym();
    word_valid = 1'b1;
    for (int i = 0; i < 15 + 16 + 5; i++) sym();

    // disable mid-word (R8)
    tx_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 idle after disable", line_out, IDLE);
    chk("R9 tx_active falls", tx_active, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 idle while off", line_out, IDLE);
      chk("R8 ready low while off", word_ready, 1'b0);
    end
    tx_en = 1'b1;
    model_restart();
    @(posedge clk); @(negedge clk);
    // first tick after re-enable must refill (R8)
    repeat (DIV - 2) @(posedge clk);
    @(negedge clk);
    chk("R8 fresh fetch after re-enable", word_ready, 1'b1);
    cur_word = word_data; bidx = 1;
    @(posedge clk); @(negedge clk);
    chk("R8 restart drives idle", line_out, IDLE);
    lvl_next = cur_word[0] ? IDLE : ~IDLE;
    wp = (wp + 1) % 8; word_data = words[wp];
    for (int i = 0; i < 40; i++) sym();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule